// File: doc/BRIEF.md
# Pipelined FIR Filter with Registered Adder Tree

This block filters a stream of unsigned pixel samples with a finite impulse response kernel of TAPS coefficients. The newest TAPS accepted samples form a window. Every window position is multiplied by its own signed coefficient in one registered stage. A binary tree of registered adders then reduces the products, halving their number at each level. A final register divides the total by TAPS with an arithmetic right shift of log2(TAPS), which truncates toward minus infinity.

Samples arrive with a valid strobe and leave with a valid strobe. While input is continuous, the block takes one sample and produces one result on every clock, after a fixed latency. A plain address/data/enable port loads the coefficients. For colour data, the block is instantiated once for each channel.

Top module: `pix_fir_tree`

## Requirements
- R1: While `rst_n` is low, `out_valid` and `out_data` are zero.
- R2: After reset, no result is produced until TAPS samples have been accepted. The first result belongs to the TAPS-th accepted sample.
- R3: Each result equals floor(sum over k of w[k]*c[k] / TAPS), taken as the upper bits of the full-precision sum. Here w[k] is the sample accepted k samples before the newest one (k=0 is the newest). Pixels are unsigned PIX_W bits and coefficients are two's complement COEF_W bits. The result is a signed value of PIX_W+COEF_W+1 bits and never overflows.
- R4: A result appears on `out_valid`/`out_data` exactly log2(TAPS)+2 rising edges after the edge that accepted its sample.
- R5: Every accepted sample from the TAPS-th onward yields exactly one result, in order. With continuous input, results come out on consecutive cycles.
- R6: A cycle with `in_valid` low does not shift the window and produces no result. `out_data` keeps its value while `out_valid` is low.
- R7: When `cw_en` is high at an edge, coefficient `cw_addr` becomes `cw_data`. Index k weights w[k]. The new value applies to the sample accepted at that same edge and to every later sample.
- R8: Reset sets all coefficients to zero and empties the window. Without writes, results after refill are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_valid | input | 1 | Sample strobe |
| in_pix | input | PIX_W | Unsigned pixel sample |
| cw_en | input | 1 | Coefficient write enable |
| cw_addr | input | log2(TAPS) | Coefficient index (0 weights the newest sample) |
| cw_data | input | COEF_W | Signed coefficient value |
| out_valid | output | 1 | Result strobe |
| out_data | output | PIX_W+COEF_W+1 | Signed filtered result |

## Verification
The bench builds the block with its defaults: 32 taps, 8-bit pixels and 12-bit coefficients. This gives a five-level tree and a latency of seven edges. These values make both extreme sums reachable: every coefficient at -2048 or at +2047 against full-scale pixels. They also make the floor behaviour of negative sums that are not multiples of 32 reachable through ramp and alternating kernels. Coefficient rewrites during streaming, idle gaps and a mid-run reset are checked against a reference model of the window, which is kept in step with the inputs.

// File: rtl/pft_pkg.sv
`timescale 1ns/1ps
package pft_pkg;
  // Width of one tap product: unsigned pixel widened by a sign bit, times a signed coefficient.
  function automatic int prod_width(int pix_w, int coef_w);
    return pix_w + 1 + coef_w;
  endfunction

  // Full-precision sum width: one extra bit per adder level.
  function automatic int sum_width(int prod_w, int taps);
    return prod_w + $clog2(taps);
  endfunction
endpackage

// File: rtl/pft_window.sv
`timescale 1ns/1ps
module pft_window #(
  parameter int TAPS  = 32,
  parameter int PIX_W = 8
) (
  input  logic                       clk,
  input  logic                       rst_ni,
  input  logic                       in_valid,
  input  logic [PIX_W-1:0]           in_pix,
  output logic [TAPS-1:0][PIX_W-1:0] win_o,
  output logic                       win_vld_o
);
  localparam int CNT_W = $clog2(TAPS + 1);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(TAPS);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(TAPS - 1);

  logic [TAPS-1:0][PIX_W-1:0] win_q, win_d;
  logic [CNT_W-1:0]           cnt_q, cnt_d;
  logic                       vld_q, vld_d;

  always_comb begin
    win_d = win_q;
    cnt_d = cnt_q;
    vld_d = 1'b0;
    if (in_valid) begin
      win_d = {win_q[TAPS-2:0], in_pix};
      if (cnt_q != FULL) cnt_d = cnt_q + 1'b1;
      vld_d = (cnt_q >= LAST);
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      win_q <= '0;
      cnt_q <= '0;
      vld_q <= 1'b0;
    end else begin
      win_q <= win_d;
      cnt_q <= cnt_d;
      vld_q <= vld_d;
    end
  end

  assign win_o     = win_q;
  assign win_vld_o = vld_q;
endmodule

// File: rtl/pft_mult.sv
`timescale 1ns/1ps
module pft_mult #(
  parameter int TAPS   = 32,
  parameter int PIX_W  = 8,
  parameter int COEF_W = 12,
  parameter int PROD_W = 21
) (
  input  logic                        clk,
  input  logic                        rst_ni,
  input  logic [TAPS-1:0][PIX_W-1:0]  win_i,
  input  logic                        win_vld_i,
  input  logic                        cw_en,
  input  logic [$clog2(TAPS)-1:0]     cw_addr,
  input  logic [COEF_W-1:0]           cw_data,
  output logic [TAPS-1:0][PROD_W-1:0] prod_o,
  output logic                        prod_vld_o
);
  logic [TAPS-1:0][COEF_W-1:0] coef_q, coef_d;
  logic [TAPS-1:0][PROD_W-1:0] prod_q;
  logic                        vld_q;

  always_comb begin
    coef_d = coef_q;
    if (cw_en) coef_d[cw_addr] = cw_data;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      coef_q <= '0;
      vld_q  <= 1'b0;
    end else begin
      coef_q <= coef_d;
      vld_q  <= win_vld_i;
    end
  end

  for (genvar i = 0; i < TAPS; i++) begin : g_tap
    always_ff @(posedge clk or negedge rst_ni) begin
      if (!rst_ni) begin
        prod_q[i] <= '0;
      end else if (win_vld_i) begin
        prod_q[i] <= $signed(PROD_W'({1'b0, win_i[i]})) *
                     $signed(PROD_W'($signed(coef_q[i])));
      end
    end
  end

  assign prod_o     = prod_q;
  assign prod_vld_o = vld_q;
endmodule

// File: rtl/pft_tree.sv
`timescale 1ns/1ps
module pft_tree #(
  parameter int TAPS   = 32,
  parameter int PROD_W = 21,
  parameter int SUM_W  = 26
) (
  input  logic                        clk,
  input  logic                        rst_ni,
  input  logic [TAPS-1:0][PROD_W-1:0] prod_i,
  input  logic                        prod_vld_i,
  output logic [SUM_W-1:0]            sum_o,
  output logic                        sum_vld_o
);
  localparam int LVL = $clog2(TAPS);

  for (genvar l = 0; l < LVL; l++) begin : g_lvl
    localparam int N = TAPS >> (l + 1);
    localparam int W = PROD_W + l + 1;
    logic [W-1:0] s [N];
    logic         v;

    if (l == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_ni) begin
        if (!rst_ni) begin
          for (int i = 0; i < N; i++) s[i] <= '0;
          v <= 1'b0;
        end else begin
          v <= prod_vld_i;
          if (prod_vld_i) begin
            for (int i = 0; i < N; i++)
              s[i] <= {prod_i[2*i][PROD_W-1], prod_i[2*i]} +
                      {prod_i[2*i+1][PROD_W-1], prod_i[2*i+1]};
          end
        end
      end
    end else begin : g_rest
      always_ff @(posedge clk or negedge rst_ni) begin
        if (!rst_ni) begin
          for (int i = 0; i < N; i++) s[i] <= '0;
          v <= 1'b0;
        end else begin
          v <= g_lvl[l-1].v;
          if (g_lvl[l-1].v) begin
            for (int i = 0; i < N; i++)
              s[i] <= {g_lvl[l-1].s[2*i][W-2], g_lvl[l-1].s[2*i]} +
                      {g_lvl[l-1].s[2*i+1][W-2], g_lvl[l-1].s[2*i+1]};
          end
        end
      end
    end
  end

  assign sum_o     = g_lvl[LVL-1].s[0];
  assign sum_vld_o = g_lvl[LVL-1].v;
endmodule

// File: rtl/pix_fir_tree.sv
`timescale 1ns/1ps
module pix_fir_tree
  import pft_pkg::*;
#(
  parameter int TAPS   = 32,
  parameter int PIX_W  = 8,
  parameter int COEF_W = 12
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      in_valid,
  input  logic [PIX_W-1:0]          in_pix,
  input  logic                      cw_en,
  input  logic [$clog2(TAPS)-1:0]   cw_addr,
  input  logic [COEF_W-1:0]         cw_data,
  output logic                      out_valid,
  output logic [PIX_W+COEF_W:0]     out_data
);
  localparam int LVL    = $clog2(TAPS);
  localparam int PROD_W = prod_width(PIX_W, COEF_W);
  localparam int SUM_W  = sum_width(PROD_W, TAPS);
  localparam int OUT_W  = PIX_W + COEF_W + 1;

  // Reset: asserted asynchronously, released on the clock.
  logic [1:0] rst_sync_q;
  logic       rst_i;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_i = rst_sync_q[1];

  logic [TAPS-1:0][PIX_W-1:0]  win;
  logic                        win_vld;
  logic [TAPS-1:0][PROD_W-1:0] prod;
  logic                        prod_vld;
  logic [SUM_W-1:0]            sum;
  logic                        sum_vld;

  pft_window #(.TAPS(TAPS), .PIX_W(PIX_W)) u_window (
    .clk(clk), .rst_ni(rst_i), .in_valid(in_valid), .in_pix(in_pix),
    .win_o(win), .win_vld_o(win_vld)
  );

  pft_mult #(.TAPS(TAPS), .PIX_W(PIX_W), .COEF_W(COEF_W), .PROD_W(PROD_W)) u_mult (
    .clk(clk), .rst_ni(rst_i), .win_i(win), .win_vld_i(win_vld),
    .cw_en(cw_en), .cw_addr(cw_addr), .cw_data(cw_data),
    .prod_o(prod), .prod_vld_o(prod_vld)
  );

  pft_tree #(.TAPS(TAPS), .PROD_W(PROD_W), .SUM_W(SUM_W)) u_tree (
    .clk(clk), .rst_ni(rst_i), .prod_i(prod), .prod_vld_i(prod_vld),
    .sum_o(sum), .sum_vld_o(sum_vld)
  );

  // Normalising stage: floor division by TAPS.
  logic [OUT_W-1:0] out_q, out_d;
  logic             ov_q;

  always_comb begin
    out_d = out_q;
    if (sum_vld) out_d = OUT_W'($signed(sum) >>> LVL);
  end

  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) begin
      out_q <= '0;
      ov_q  <= 1'b0;
    end else begin
      out_q <= out_d;
      ov_q  <= sum_vld;
    end
  end

  assign out_valid = ov_q;
  assign out_data  = out_q;
endmodule

// File: rtl/pft_chk.sv
`timescale 1ns/1ps
module pft_chk #(
  parameter int TAPS  = 32,
  parameter int OUT_W = 21,
  parameter int LAT   = 7
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             out_valid,
  input logic [OUT_W-1:0] out_data
);
  localparam int CNT_W = $clog2(TAPS + 1);

  logic [CNT_W-1:0] acc_cnt;
  logic [LAT:0]     due;
  logic             take;

  assign take = in_valid && (int'(acc_cnt) >= TAPS - 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_cnt <= '0;
      due     <= '0;
    end else begin
      if (in_valid && int'(acc_cnt) != TAPS) acc_cnt <= acc_cnt + 1'b1;
      due <= {due[LAT-1:0], take};
    end
  end

  // R2: no result before the window has filled
  p_no_early_out_r2: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (int'(acc_cnt) == TAPS));

  // R4: a result emerges exactly LAT edges after its sample
  p_fixed_latency_r4: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid == due[LAT]);

  // R6: output data holds while no result is presented
  p_hold_data_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> $stable(out_data));

  // R5: back-to-back accepted samples give back-to-back results
  p_stream_rate_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (due[LAT] && due[LAT-1]) |=> (out_valid && $past(out_valid)));
endmodule

bind pix_fir_tree pft_chk #(
  .TAPS(TAPS), .OUT_W(PIX_W + COEF_W + 1), .LAT($clog2(TAPS) + 2)
) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
  .out_valid(out_valid), .out_data(out_data)
);

// File: tb/pix_fir_tree_bench.sv
`timescale 1ns/1ps
module pix_fir_tree_bench;
  localparam int TAPS   = 32;
  localparam int PIX_W  = 8;
  localparam int COEF_W = 12;
  localparam int LVL    = $clog2(TAPS);
  localparam int AW     = LVL;
  localparam int OUT_W  = PIX_W + COEF_W + 1;
  localparam int LAT    = LVL + 2;
  localparam int QD     = 1024;

  // Row: {coef kind, pixel kind, gap period, length, requirement number}
  localparam int NV = 8;
  localparam logic [23:0] VEC [NV] = '{
    {4'd2, 4'd0, 4'd0, 8'd48, 4'd3},
    {4'd3, 4'd1, 4'd0, 8'd40, 4'd3},
    {4'd4, 4'd1, 4'd0, 8'd40, 4'd3},
    {4'd5, 4'd3, 4'd0, 8'd48, 4'd7},
    {4'd6, 4'd2, 4'd3, 8'd60, 4'd6},
    {4'd1, 4'd3, 4'd2, 8'd50, 4'd6},
    {4'd2, 4'd3, 4'd0, 8'd64, 4'd7},
    {4'd3, 4'd2, 4'd0, 8'd40, 4'd3}
  };

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic                    rst_n;
  logic                    in_valid;
  logic [PIX_W-1:0]        in_pix;
  logic                    cw_en;
  logic [AW-1:0]           cw_addr;
  logic [COEF_W-1:0]       cw_data;
  logic                    out_valid;
  logic signed [OUT_W-1:0] out_data;

  pix_fir_tree #(.TAPS(TAPS), .PIX_W(PIX_W), .COEF_W(COEF_W)) u_pix_fir_tree (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_pix(in_pix),
    .cw_en(cw_en), .cw_addr(cw_addr), .cw_data(cw_data),
    .out_valid(out_valid), .out_data(out_data)
  );

  int     checks = 0;
  int     errors = 0;
  int     cyc = 0;
  int     m_coef [TAPS];
  int     m_win  [TAPS];
  int     m_cnt = 0;
  longint q_val  [QD];
  int     q_stamp[QD];
  int     q_h = 0;
  int     q_t = 0;
  int     n_out = 0;
  int     run = 0;
  int     max_run = 0;
  int     lcg = 1;
  string  cur_req = "R3";

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(bit ok, string req, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Output monitor, sampled away from the active edge.
  always @(negedge clk) begin
    if (rst_n && out_valid) begin
      n_out++;
      run++;
      if (run > max_run) max_run = run;
      if (q_h == q_t) begin
        chk(1'b0, "R2", 1, 0);
      end else begin
        chk(longint'(out_data) == q_val[q_h % QD], cur_req,
            longint'(out_data), q_val[q_h % QD]);
        chk(cyc - q_stamp[q_h % QD] == LAT, "R4",
            cyc - q_stamp[q_h % QD], LAT);
        q_h++;
      end
    end else begin
      run = 0;
    end
  end

  task automatic model_clear();
    for (int i = 0; i < TAPS; i++) begin
      m_coef[i] = 0;
      m_win[i]  = 0;
    end
    m_cnt = 0;
    q_h = 0;
    q_t = 0;
  endtask

  task automatic step(bit v, int pix, bit we, int wa, int wd);
    longint acc;
    @(negedge clk);
    in_valid = v;
    in_pix   = pix[PIX_W-1:0];
    cw_en    = we;
    cw_addr  = wa[AW-1:0];
    cw_data  = wd[COEF_W-1:0];
    @(posedge clk);
    #1;
    if (we) m_coef[wa] = wd;
    if (v) begin
      for (int i = TAPS - 1; i > 0; i--) m_win[i] = m_win[i-1];
      m_win[0] = pix;
      if (m_cnt < TAPS) m_cnt++;
      if (m_cnt == TAPS) begin
        acc = 0;
        for (int i = 0; i < TAPS; i++) acc += longint'(m_win[i]) * longint'(m_coef[i]);
        q_val[q_t % QD]   = acc >>> LVL;
        q_stamp[q_t % QD] = cyc;
        q_t++;
      end
    end
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) step(1'b0, 0, 1'b0, 0, 0);
  endtask

  function automatic int cval(int kind, int i);
    case (kind)
      1: return 1;
      2: return i - 16;
      3: return -2048;
      4: return 2047;
      5: return (i == 3) ? 64 : 0;
      6: return (i % 2 == 1) ? -700 : 900;
      default: return 0;
    endcase
  endfunction

  function automatic int pval(int kind, int n);
    case (kind)
      1: return 255;
      2: return (n % 2 == 1) ? 255 : 0;
      3: begin
        lcg = lcg * 1103515245 + 12345;
        return (lcg >>> 16) & 255;
      end
      default: return (n * 7) & 255;
    endcase
  endfunction

  task automatic apply_reset();
    @(negedge clk);
    rst_n = 1'b0;
    in_valid = 1'b0;
    cw_en = 1'b0;
    model_clear();
    repeat (3) @(negedge clk);
    chk(out_valid == 1'b0, "R1", out_valid, 0);
    chk(out_data == '0, "R1", out_data, 0);
    rst_n = 1'b1;
    idle(4);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL R5 watchdog actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : main
    rst_n = 1'b0;
    in_valid = 1'b0;
    in_pix = '0;
    cw_en = 1'b0;
    cw_addr = '0;
    cw_data = '0;
    model_clear();

    // R1 reset state, then R2 fill and R8 zero coefficients
    apply_reset();
    cur_req = "R8";
    for (int n = 0; n < TAPS - 1; n++) step(1'b1, 200 - n, 1'b0, 0, 0);
    idle(LAT + 3);
    chk(n_out == 0, "R2", n_out, 0);
    step(1'b1, 99, 1'b0, 0, 0);
    idle(LAT + 2);
    chk(n_out == 1, "R2", n_out, 1);

    // Vector table: kernels and pixel patterns, coefficient writes while streaming
    for (int r = 0; r < NV; r++) begin
      int ck, pk, gp, ln, rq;
      ck = int'(VEC[r][23:20]);
      pk = int'(VEC[r][19:16]);
      gp = int'(VEC[r][15:12]);
      ln = int'(VEC[r][11:4]);
      rq = int'(VEC[r][3:0]);
      cur_req = $sformatf("R%0d", rq);
      for (int n = 0; n < ln; n++) begin
        if (gp != 0 && (n % gp) == gp - 1) idle(1);
        step(1'b1, pval(pk, n), n < TAPS, n % TAPS, cval(ck, n % TAPS));
      end
    end
    idle(LAT + 3);
    chk(q_h == q_t, "R5", q_t - q_h, 0);

    // R7: a write during an idle cycle applies to the next sample
    cur_req = "R7";
    step(1'b0, 0, 1'b1, 0, -1500);
    step(1'b1, 250, 1'b0, 0, 0);
    step(1'b0, 0, 1'b1, TAPS - 1, 1999);
    step(1'b1, 17, 1'b0, 0, 0);
    idle(LAT + 3);

    // R5: continuous stream gives consecutive results
    cur_req = "R5";
    max_run = 0;
    for (int n = 0; n < 40; n++) step(1'b1, pval(3, n), 1'b0, 0, 0);
    idle(LAT + 3);
    chk(max_run >= 40, "R5", max_run, 40);
    chk(q_h == q_t, "R5", q_t - q_h, 0);

    // R6: idle cycles with no write leave the output untouched
    begin
      longint held;
      held = longint'(out_data);
      idle(6);
      chk(out_valid == 1'b0, "R6", out_valid, 0);
      chk(longint'(out_data) == held, "R6", longint'(out_data), held);
    end

    // R8: reset mid-run clears coefficients and window
    apply_reset();
    cur_req = "R8";
    n_out = 0;
    for (int n = 0; n < TAPS + 4; n++) step(1'b1, 255, 1'b0, 0, 0);
    idle(LAT + 3);
    chk(n_out == 5, "R8", n_out, 5);
    chk(out_data == '0, "R8", longint'(out_data), 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule